// File: doc/BRIEF.md
# Supervisor Mode Register Controller

This block is the digital core behind the mode register of a supervisor chip. A host sends 16-bit words over a serial-style link. Each word carries a target address, a choice of which companion register to read back, and a read-only flag. When the word really writes the mode register, it also carries a watchdog period, an operating-mode code, a development-mode flag and the level for an enable output. The block decodes each access and rejects writes whose mode or watchdog coding is illegal. It keeps the operating mode and counts the watchdog and start-up deadlines. When a rule is broken it forces a one-cycle system reset request and records why.

A legal mode write is the only thing that services the watchdog. A special entry path into flash mode is protected: the host must write normal, flash, normal, flash in that order. The last of those writes forces a reset and marks the reset source as flash entry. An initialize-flash write made during the following start-up window then puts the block in flash mode.

Top module: `supmode_ctrl`

## Requirements
- R1: A legal write (address bits 15:14 = 00, read-only bit 12 = 0) loads the enable output from bit 1, the development flag from bit 2 and the watchdog code from bits 11:6, all visible the cycle after the write. The mode code sits in bits 5:3, the read-select in bit 13, and bit 0 is reserved.
- R2: A word with read-only = 1, or with an address other than 00, leaves op_mode, en_out, dev_mode and wd_code unchanged. Every address-00 access pulses rd_stb for one cycle and latches bit 13 into rd_diag (1 = diagnosis, 0 = status). Other addresses give no pulse.
- R3: A write with mode code 000 or watchdog code 0 is discarded. The next cycle shows sys_rst_req = 1 for exactly one cycle, rst_src = 0010, op_mode = 000 (start-up), and en_out, dev_mode and wd_code cleared. Words that arrive while sys_rst_req is high are ignored.
- R4: A legal write of code 001, 010, 100, 101 or 110 sets op_mode to that code. Code 011 sets op_mode to 011 unless R9 applies. Code 111 leaves op_mode unchanged.
- R5: In start-up (op_mode 000), if no legal write arrives within INIT_WIN cycles of the last reset, a reset is forced with rst_src = 0010.
- R6: Outside start-up, if no legal write arrives within (wd_code+1)*WD_UNIT cycles of the last one, a reset is forced with rst_src = 0010.
- R7: With dev_mode = 1 outside start-up, the watchdog timeout of R6 never forces a reset.
- R8: Four consecutive legal writes with mode codes 001, 111, 001, 111 force a reset on the last one, with rst_src = 0100 and op_mode = 000.
- R9: After an R8 reset, a legal 011 write in start-up sets op_mode to 111. Any legal write outside the expected order restarts the sequence; a 001 counts as its first step.
- R10: After rst_n, op_mode = 000, rst_src = 0001, and en_out, dev_mode, wd_code, sys_rst_req and rd_stb are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| wr_valid | input | 1 | A received word is present this cycle |
| wr_data | input | 16 | Received word |
| op_mode | output | 3 | Current operating mode, 000 = start-up |
| en_out | output | 1 | Enable output level |
| dev_mode | output | 1 | Development mode active |
| wd_code | output | 6 | Current watchdog period code |
| rst_src | output | 4 | Cause of the latest reset |
| sys_rst_req | output | 1 | One-cycle forced system reset request |
| rd_stb | output | 1 | Mode-register access seen, read-back due |
| rd_diag | output | 1 | Latched read-select of the last access |

## Verification
A wrong watchdog count shows as a sys_rst_req pulse one cycle early or late relative to the last legal write. A broken sequence tracker either fails to force the flash reset on the fourth write or forces it on a scrambled order, so rst_src reads 0100 when it should not. A stale armed flag shows one write later, when an initialize-flash write in start-up gives op_mode 111 instead of 011. Field decoding faults appear on en_out, dev_mode or wd_code the cycle after the write.

// File: rtl/supmode_pkg.sv
package supmode_pkg;

  typedef struct packed {
    logic [1:0] addr;
    logic       rd_diag;
    logic       ro;
    logic [5:0] wd;
    logic [2:0] mode;
    logic       dev;
    logic       en;
    logic       rsv;
  } mode_word_t;

  localparam logic [1:0] ADDR_MODE = 2'b00;

  localparam logic [2:0] M_START   = 3'd0;
  localparam logic [2:0] M_NORMAL  = 3'd1;
  localparam logic [2:0] M_STANDBY = 3'd2;
  localparam logic [2:0] M_INITFL  = 3'd3;
  localparam logic [2:0] M_SLEEP   = 3'd4;
  localparam logic [2:0] M_INITNM  = 3'd5;
  localparam logic [2:0] M_LEAVEFL = 3'd6;
  localparam logic [2:0] M_FLASH   = 3'd7;

  localparam logic [3:0] SRC_POR   = 4'b0001;
  localparam logic [3:0] SRC_WDOG  = 4'b0010;
  localparam logic [3:0] SRC_FLASH = 4'b0100;

  function automatic logic word_legal(mode_word_t w);
    return (w.mode != M_START) && (w.wd != '0);
  endfunction

  function automatic logic [2:0] next_mode(logic [2:0] cur, logic [2:0] code, logic armed);
    if (code == M_FLASH) return cur;
    if (code == M_INITFL && armed && cur == M_START) return M_FLASH;
    return code;
  endfunction

endpackage

// File: rtl/supmode_decode.sv
module supmode_decode
  import supmode_pkg::*;
(
  input  logic        wr_valid,
  input  logic [15:0] wr_data,
  input  logic        blocked,
  output mode_word_t  word,
  output logic        acc_ev,
  output logic        svc_ev,
  output logic        ill_ev
);
  logic wr_ev;
  logic unused_rsv;

  assign word       = mode_word_t'(wr_data);
  assign unused_rsv = word.rsv;
  assign acc_ev     = wr_valid && !blocked && (word.addr == ADDR_MODE);
  assign wr_ev      = acc_ev && !word.ro;
  assign svc_ev     = wr_ev && word_legal(word);
  assign ill_ev     = wr_ev && !word_legal(word);
endmodule

// File: rtl/supmode_wdog.sv
module supmode_wdog #(
  parameter int WD_UNIT  = 4,
  parameter int INIT_WIN = 64,
  parameter int WD_W     = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            svc,
  input  logic            force_clr,
  input  logic            startup,
  input  logic            dev,
  input  logic [WD_W-1:0] wd_code,
  output logic            timeout
);
  localparam int MAXP = (1 << WD_W) * WD_UNIT;
  localparam int MAXL = (INIT_WIN > MAXP) ? INIT_WIN : MAXP;
  localparam int CW   = $clog2(MAXL + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;
  logic          at_end;
  logic          suppress;

  function automatic logic [CW-1:0] limit_of(logic st, logic [WD_W-1:0] code);
    if (st) return CW'(INIT_WIN);
    return CW'((int'(code) + 1) * WD_UNIT);
  endfunction

  assign limit    = limit_of(startup, wd_code);
  assign at_end   = (cnt == limit - CW'(1));
  assign suppress = dev && !startup;
  assign timeout  = at_end && !svc && !suppress;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (svc || force_clr) cnt <= '0;
    else if (!at_end)         cnt <= cnt + CW'(1);
  end

  AST_WD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < limit); // R6
endmodule

// File: rtl/supmode_flashseq.sv
module supmode_flashseq
  import supmode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       svc,
  input  logic [2:0] code,
  input  logic       clr,
  output logic       fire
);
  logic [1:0] step;
  logic [1:0] step_nx;

  always_comb begin
    step_nx = step;
    if (svc) begin
      unique case (step)
        2'd0: step_nx = (code == M_NORMAL) ? 2'd1 : 2'd0;
        2'd1: step_nx = (code == M_FLASH) ? 2'd2 : ((code == M_NORMAL) ? 2'd1 : 2'd0);
        2'd2: step_nx = (code == M_NORMAL) ? 2'd3 : 2'd0;
        default: step_nx = (code == M_NORMAL) ? 2'd1 : 2'd0;
      endcase
    end
  end

  assign fire = svc && (step == 2'd3) && (code == M_FLASH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   step <= 2'd0;
    else if (clr) step <= 2'd0;
    else          step <= step_nx;
  end

  AST_SEQ_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (step == 2'd2 && $past(step) != 2'd2) |-> ($past(step) == 2'd1)); // R9
endmodule

// File: rtl/supmode_ctrl.sv
module supmode_ctrl
  import supmode_pkg::*;
#(
  parameter int WD_UNIT  = 4,
  parameter int INIT_WIN = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_valid,
  input  logic [15:0] wr_data,
  output logic [2:0]  op_mode,
  output logic        en_out,
  output logic        dev_mode,
  output logic [5:0]  wd_code,
  output logic [3:0]  rst_src,
  output logic        sys_rst_req,
  output logic        rd_stb,
  output logic        rd_diag
);
  mode_word_t word;
  logic acc_ev, svc_ev, ill_ev, timeout_ev, fire_ev, force_ev;
  logic armed_q;

  supmode_decode u_dec (
    .wr_valid(wr_valid), .wr_data(wr_data), .blocked(sys_rst_req),
    .word(word), .acc_ev(acc_ev), .svc_ev(svc_ev), .ill_ev(ill_ev)
  );

  supmode_wdog #(.WD_UNIT(WD_UNIT), .INIT_WIN(INIT_WIN), .WD_W(6)) u_wd (
    .clk(clk), .rst_n(rst_n), .svc(svc_ev), .force_clr(force_ev),
    .startup(op_mode == M_START), .dev(dev_mode), .wd_code(wd_code),
    .timeout(timeout_ev)
  );

  supmode_flashseq u_seq (
    .clk(clk), .rst_n(rst_n), .svc(svc_ev), .code(word.mode),
    .clr(force_ev), .fire(fire_ev)
  );

  assign force_ev = ill_ev || timeout_ev || fire_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_mode <= M_START; en_out <= 1'b0; dev_mode <= 1'b0; wd_code <= '0;
      rst_src <= SRC_POR; sys_rst_req <= 1'b0; armed_q <= 1'b0;
      rd_stb <= 1'b0; rd_diag <= 1'b0;
    end else begin
      rd_stb      <= acc_ev;
      sys_rst_req <= force_ev;
      if (acc_ev) rd_diag <= word.rd_diag;
      if (force_ev) begin
        op_mode  <= M_START;
        en_out   <= 1'b0;
        dev_mode <= 1'b0;
        wd_code  <= '0;
        armed_q  <= fire_ev;
        rst_src  <= fire_ev ? SRC_FLASH : SRC_WDOG;
      end else if (svc_ev) begin
        en_out   <= word.en;
        dev_mode <= word.dev;
        wd_code  <= word.wd;
        op_mode  <= next_mode(op_mode, word.mode, armed_q);
        armed_q  <= 1'b0;
      end
    end
  end

  AST_ILLEGAL_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    ill_ev |=> (sys_rst_req && rst_src == SRC_WDOG && op_mode == M_START)); // R3
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> !sys_rst_req); // R3
  AST_RO_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ev && word.ro && !force_ev) |=> ($stable(op_mode) && $stable(en_out) && $stable(wd_code))); // R2
  AST_FLASH_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    fire_ev |=> (rst_src == SRC_FLASH && op_mode == M_START && sys_rst_req)); // R8
  AST_DEV_NO_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_mode && op_mode != M_START && !wr_valid) |=> !sys_rst_req); // R7
  AST_ARMED_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && svc_ev && !force_ev && word.mode == M_INITFL && op_mode == M_START) |=> (op_mode == M_FLASH)); // R9
endmodule

// File: tb/supmode_ctrl_tb_top.sv
`timescale 1ns/1ps
module supmode_ctrl_tb_top;
  localparam int UNIT = 4;
  localparam int INIT = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [15:0] wr_data = '0;
  logic [2:0] op_mode;
  logic en_out, dev_mode, sys_rst_req, rd_stb, rd_diag;
  logic [5:0] wd_code;
  logic [3:0] rst_src;

  int vecs = 0;
  int miss = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  supmode_ctrl #(.WD_UNIT(UNIT), .INIT_WIN(INIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .op_mode(op_mode), .en_out(en_out), .dev_mode(dev_mode), .wd_code(wd_code),
    .rst_src(rst_src), .sys_rst_req(sys_rst_req), .rd_stb(rd_stb), .rd_diag(rd_diag)
  );

  // reference state
  int m_mode, m_src, m_en, m_dev, m_wd, m_req, m_cnt, m_step, m_armed, m_stb, m_diag;
  int n_mode, n_src, n_en, n_dev, n_wd, n_req, n_cnt, n_step, n_armed, n_stb, n_diag;

  function automatic logic [15:0] mk(int a, int dg, int ro, int wd, int m, int dv, int e);
    return {a[1:0], dg[0], ro[0], wd[5:0], m[2:0], dv[0], e[0], 1'b0};
  endfunction

  function automatic int period_of(int startup, int wd);
    return startup ? INIT : (wd + 1) * UNIT;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      miss++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_mode = 0; m_src = 1; m_en = 0; m_dev = 0; m_wd = 0; m_req = 0;
    m_cnt = 0; m_step = 0; m_armed = 0; m_stb = 0; m_diag = 0;
  endtask

  task automatic model_next(input logic v, input logic [15:0] d);
    int code, acc, wr, legal, svc, ill, st, tmo, fire;
    code = int'(d[5:3]);
    acc = (v && m_req == 0 && d[15:14] == 2'b00) ? 1 : 0;
    wr = (acc == 1 && !d[12]) ? 1 : 0;
    legal = (code != 0 && d[11:6] != 0) ? 1 : 0;
    svc = wr & legal;
    ill = wr & ~legal & 1;
    st = (m_mode == 0) ? 1 : 0;
    tmo = (svc == 0 && m_cnt == period_of(st, m_wd) - 1 && !(m_dev == 1 && st == 0)) ? 1 : 0;
    fire = (svc == 1 && m_step == 3 && code == 7) ? 1 : 0;
    n_mode = m_mode; n_src = m_src; n_en = m_en; n_dev = m_dev; n_wd = m_wd;
    n_armed = m_armed; n_step = m_step;
    n_stb = acc; n_diag = acc ? int'(d[13]) : m_diag;
    n_req = (ill | tmo | fire);
    if (n_req == 1) begin
      n_mode = 0; n_en = 0; n_dev = 0; n_wd = 0; n_cnt = 0; n_step = 0;
      n_armed = fire; n_src = fire ? 4 : 2;
    end else begin
      n_cnt = svc ? 0 : ((m_cnt == period_of(st, m_wd) - 1) ? m_cnt : m_cnt + 1);
      if (svc == 1) begin
        n_en = int'(d[1]); n_dev = int'(d[2]); n_wd = int'(d[11:6]);
        if (code == 7) n_mode = m_mode;
        else if (code == 3 && m_armed == 1 && st == 1) n_mode = 7;
        else n_mode = code;
        n_armed = 0;
        if (m_step == 1 && code == 7) n_step = 2;
        else if (m_step == 2) n_step = (code == 1) ? 3 : 0;
        else n_step = (code == 1) ? 1 : 0;
      end
    end
  endtask

  task automatic cyc(input logic v, input logic [15:0] d);
    @(negedge clk);
    wr_valid = v; wr_data = d;
    model_next(v, d);
    @(posedge clk); #1;
    m_mode = n_mode; m_src = n_src; m_en = n_en; m_dev = n_dev; m_wd = n_wd;
    m_req = n_req; m_cnt = n_cnt; m_step = n_step; m_armed = n_armed;
    m_stb = n_stb; m_diag = n_diag;
    chk("R4 model op_mode", int'(op_mode), m_mode);
    chk("R1 model en_out", int'(en_out), m_en);
    chk("R1 model dev_mode", int'(dev_mode), m_dev);
    chk("R1 model wd_code", int'(wd_code), m_wd);
    chk("R8 model rst_src", int'(rst_src), m_src);
    chk("R6 model sys_rst_req", int'(sys_rst_req), m_req);
    chk("R2 model rd_stb", int'(rd_stb), m_stb);
    chk("R2 model rd_diag", int'(rd_diag), m_diag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 16'h0000);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      miss++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #0.1;
    chk("R10 reset op_mode", int'(op_mode), 0);
    chk("R10 reset rst_src", int'(rst_src), 1);
    chk("R10 reset en_out", int'(en_out), 0);
    chk("R10 reset sys_rst_req", int'(sys_rst_req), 0);
    chk("R10 reset rd_stb", int'(rd_stb), 0);

    // R1 field load
    cyc(1'b1, mk(0, 0, 0, 3, 1, 0, 1));
    chk("R1 en_out loaded", int'(en_out), 1);
    chk("R1 wd_code loaded", int'(wd_code), 3);
    chk("R4 normal code", int'(op_mode), 1);
    // R2 read-only access
    cyc(1'b1, mk(0, 1, 1, 9, 2, 1, 0));
    chk("R2 ro keeps op_mode", int'(op_mode), 1);
    chk("R2 ro keeps en_out", int'(en_out), 1);
    chk("R2 ro strobe", int'(rd_stb), 1);
    chk("R2 ro diag select", int'(rd_diag), 1);
    // R2 other address
    cyc(1'b1, mk(1, 0, 0, 9, 2, 1, 0));
    chk("R2 other addr keeps wd_code", int'(wd_code), 3);
    chk("R2 other addr no strobe", int'(rd_stb), 0);
    // R6 watchdog exact
    cyc(1'b1, mk(0, 0, 0, 3, 1, 0, 1));
    idle(4 * UNIT - 1);
    chk("R6 no reset before period", int'(sys_rst_req), 0);
    idle(1);
    chk("R6 reset at period", int'(sys_rst_req), 1);
    chk("R6 source watchdog", int'(rst_src), 2);
    // R5 start-up window
    idle(INIT - 1);
    chk("R5 no reset inside window", int'(sys_rst_req), 0);
    idle(1);
    chk("R5 reset at window end", int'(sys_rst_req), 1);
    idle(1);
    // R3 illegal mode and illegal watchdog code
    cyc(1'b1, mk(0, 0, 0, 5, 2, 0, 1));
    cyc(1'b1, mk(0, 0, 0, 5, 0, 0, 1));
    chk("R3 illegal mode reset", int'(sys_rst_req), 1);
    chk("R3 illegal mode op_mode", int'(op_mode), 0);
    chk("R3 illegal mode en_out", int'(en_out), 0);
    idle(1);
    chk("R3 single pulse", int'(sys_rst_req), 0);
    cyc(1'b1, mk(0, 0, 0, 0, 1, 0, 1));
    chk("R3 illegal wd reset", int'(sys_rst_req), 1);
    chk("R3 illegal wd source", int'(rst_src), 2);
    idle(1);
    // R4 mode codes
    cyc(1'b1, mk(0, 0, 0, 20, 2, 0, 0)); chk("R4 standby", int'(op_mode), 2);
    cyc(1'b1, mk(0, 0, 0, 20, 4, 0, 0)); chk("R4 sleep", int'(op_mode), 4);
    cyc(1'b1, mk(0, 0, 0, 20, 5, 0, 0)); chk("R4 init normal", int'(op_mode), 5);
    cyc(1'b1, mk(0, 0, 0, 20, 6, 0, 0)); chk("R4 leave flash", int'(op_mode), 6);
    cyc(1'b1, mk(0, 0, 0, 20, 3, 0, 0)); chk("R4 init flash unarmed", int'(op_mode), 3);
    cyc(1'b1, mk(0, 0, 0, 20, 7, 0, 0)); chk("R4 flash code keeps mode", int'(op_mode), 3);
    // R7 development mode
    cyc(1'b1, mk(0, 0, 0, 1, 1, 1, 0));
    idle(40);
    chk("R7 dev suppresses timeout", int'(sys_rst_req), 0);
    chk("R7 dev flag", int'(dev_mode), 1);
    // R8 flash entry sequence
    cyc(1'b1, mk(0, 0, 0, 10, 1, 0, 0));
    cyc(1'b1, mk(0, 0, 0, 10, 7, 0, 0));
    cyc(1'b1, mk(0, 0, 0, 10, 1, 0, 0));
    cyc(1'b1, mk(0, 0, 0, 10, 7, 0, 0));
    chk("R8 sequence reset", int'(sys_rst_req), 1);
    chk("R8 sequence source", int'(rst_src), 4);
    chk("R8 start-up mode", int'(op_mode), 0);
    idle(1);
    cyc(1'b1, mk(0, 0, 0, 10, 3, 0, 0));
    chk("R9 armed entry to flash", int'(op_mode), 7);
    chk("R9 source kept", int'(rst_src), 4);
    // R9 broken sequence
    cyc(1'b1, mk(0, 0, 0, 10, 1, 0, 0));
    cyc(1'b1, mk(0, 0, 0, 10, 7, 0, 0));
    cyc(1'b1, mk(0, 0, 0, 10, 2, 0, 0));
    cyc(1'b1, mk(0, 0, 0, 10, 1, 0, 0));
    cyc(1'b1, mk(0, 0, 0, 10, 7, 0, 0));
    chk("R9 broken sequence no reset", int'(sys_rst_req), 0);
    chk("R9 broken sequence mode", int'(op_mode), 1);
    // R9 unarmed init-flash in start-up
    cyc(1'b1, mk(0, 0, 0, 10, 0, 0, 0));
    idle(1);
    cyc(1'b1, mk(0, 0, 0, 10, 3, 0, 0));
    chk("R9 unarmed init flash", int'(op_mode), 3);

    // constrained random
    for (int k = 0; k < 3000; k++) begin
      if (k % 600 == 300) begin
        cyc(1'b1, mk(0, 0, 0, 12, 1, 0, 1));
        cyc(1'b1, mk(0, 0, 0, 12, 7, 0, 1));
        cyc(1'b1, mk(0, 0, 0, 12, 1, 0, 1));
        cyc(1'b1, mk(0, 0, 0, 12, 7, 0, 1));
        idle(1 + int'($urandom % 3));
        cyc(1'b1, mk(0, 0, 0, 12, 3, 0, 1));
      end else if ($urandom % 4 == 0) begin
        int a, ro, wd, m;
        a  = ($urandom % 8 == 0) ? 1 + int'($urandom % 3) : 0;
        ro = ($urandom % 6 == 0) ? 1 : 0;
        wd = ($urandom % 16 == 0) ? 0 : 1 + int'($urandom % 63);
        m  = ($urandom % 12 == 0) ? 0 : 1 + int'($urandom % 7);
        cyc(1'b1, mk(a, int'($urandom % 2), ro, wd, m, ($urandom % 5 == 0) ? 1 : 0, int'($urandom % 2)));
      end else if ($urandom % 200 == 0) begin
        idle(80);
      end else begin
        cyc(1'b0, 16'(int'($urandom)));
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule